// File: doc/BRIEF.md
# Chainable Serial Result Port

This block is the device side of a serial read-out port for a 24-bit conversion result. It keeps the most recent result word in a shift register and drives it onto a serial data output, most significant bit first. An active-low select input frames the transfer and enables the output driver. The external serial clock is oversampled by the block's own clock, and each detected falling edge of the serial clock advances the output by one bit. The word is passed through unchanged, so a two's complement result leaves the port in two's complement.

Bits on the chain input are captured on the same falling edges and enter behind the outgoing word. Several devices can therefore be wired output-to-input. The host reads the whole chain from the last device's output: first that device's own word, then the next device's word, and so on. The port works with a select line that toggles around each frame. It also works with the select line held low, in which case the word appears as soon as it is loaded. A word that arrives while the device's own bits are only partly shifted out is held back. The held word is installed when the select line goes high.

Top module: `sdo_chain_port`

## Requirements
- R1: After reset the shift register is cleared: with select low and no load yet, `sdo_o` reads 0.
- R2: `sdo_oe_o` is 1 exactly while `cs_n_i` is 0, in the same cycle and without any serial clock edge.
- R3: A load with select high puts bit 23 of the word on `sdo_o` from the next clock, so the MSB is visible as soon as select falls, before any serial clock edge.
- R4: A serial clock falling edge means `sclk_i` was sampled 1 and then 0 on consecutive clocks. When this happens with select low, `sdo_o` shows the next lower bit from the clock after that sample.
- R5: A 24-bit word leaves as bit 23 down to bit 0 in that order, unchanged, so a negative two's complement value keeps its sign bit first.
- R6: `sdi_i` is captured on each serial clock falling edge. After the 24 own bits, `sdo_o` repeats the captured chain-input bits in arrival order, delayed by exactly 24 falling edges.
- R7: Serial clock edges while select is high do not move the register: a later frame still starts at the loaded word's MSB.
- R8: With select low and either no falling edge since the frame start or all 24 own bits already shifted, a load takes effect at once, so a port with select tied low can take each new word.
- R9: A load with select low after 1 to 23 falling edges of the frame is deferred. The word in flight continues bit for bit, and the deferred word's MSB appears on the clock after select rises.
- R10: When several loads are deferred within one frame, only the last one is installed at the select rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that oversamples the serial clock and select |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | One-cycle pulse offering a new result word |
| word_i | input | 24 | Result word, two's complement |
| sclk_i | input | 1 | External serial clock, sampled by `clk` |
| cs_n_i | input | 1 | Active-low select that frames the transfer |
| sdi_i | input | 1 | Chain input from the upstream device's output |
| sdo_o | output | 1 | Serial data, meaningful while `sdo_oe_o` is 1 |
| sdo_oe_o | output | 1 | Output-driver enable; 0 means high impedance |

## Verification
The assertions assume that `sclk_i` and `cs_n_i` are already synchronous to `clk`. They also assume that every level of the serial clock is held for at least one `clk` cycle, so that each falling edge is seen exactly once. The stimulus changes these inputs only just after a rising `clk` edge and holds each level for a full cycle. It offers a new word only as a single-cycle `load_i` pulse. Select is toggled only while the serial clock is low, so no frame boundary coincides with a shift.

// File: rtl/sdo_chain_pkg.sv
package sdo_chain_pkg;

  // A frame is busy while select is low and the own word is partly sent.
  function automatic logic frame_busy(input logic cs_low,
                                      input int unsigned shifted,
                                      input int unsigned width);
    return cs_low && (shifted != 0) && (shifted < width);
  endfunction

  // Saturating count of falling edges seen in the current frame.
  function automatic int unsigned count_next(input int unsigned shifted,
                                             input int unsigned width);
    return (shifted < width) ? shifted + 1 : shifted;
  endfunction

endpackage

// File: rtl/sdo_chain_edge.sv
module sdo_chain_edge #(
  parameter int N = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] fell_o,
  output logic [N-1:0] rose_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= sig_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign fell_o[g] = prev_q[g] & ~sig_i[g];
    assign rose_o[g] = ~prev_q[g] & sig_i[g];
  end
endmodule

// File: rtl/sdo_chain_frame_ctl.sv
module sdo_chain_frame_ctl
  import sdo_chain_pkg::*;
#(
  parameter int W  = 24,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_low_i,
  input  logic          cs_rise_i,
  input  logic          shift_i,
  input  logic          load_i,
  input  logic [W-1:0]  word_i,
  output logic          apply_o,
  output logic [W-1:0]  apply_word_o,
  output logic          busy_o,
  output logic          pend_v_o,
  output logic          pend_msb_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  pend_word_q;
  logic          pend_v_q;
  logic [CW-1:0] cnt_q;
  logic          direct_load;
  logic          late_load;

  assign busy_o       = frame_busy(cs_low_i, int'(cnt_q), W);
  assign direct_load  = load_i && !busy_o;
  assign late_load    = cs_rise_i && pend_v_q && !load_i;
  assign apply_o      = direct_load || late_load;
  assign apply_word_o = direct_load ? word_i : pend_word_q;
  assign pend_v_o     = pend_v_q;
  assign pend_msb_o   = pend_word_q[W-1];
  assign cnt_o        = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_word_q <= '0;
      pend_v_q    <= 1'b0;
    end else if (load_i && busy_o) begin
      pend_word_q <= word_i;
      pend_v_q    <= 1'b1;
    end else if (apply_o) begin
      pend_v_q    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (apply_o || cs_rise_i) cnt_q <= '0;
    else if (shift_i)              cnt_q <= CW'(count_next(int'(cnt_q), W));
  end
endmodule

// File: rtl/sdo_chain_shifter.sv
module sdo_chain_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  input  logic         sdi_i,
  output logic         msb_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (load_i)  sh_q <= word_i;
    else if (shift_i) sh_q <= {sh_q[W-2:0], sdi_i};
  end

  assign msb_o = sh_q[W-1];
endmodule

// File: rtl/sdo_chain_port.sv
module sdo_chain_port #(
  parameter int WORD_W = 24,
  localparam int CW = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic [1:0]        fell, rose;
  logic              shift_ev;
  logic              load_ev;
  logic              cs_rise;
  logic              busy;
  logic              pend_v;
  logic              pend_msb;
  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] load_word;

  // bit 1: select, bit 0: serial clock
  sdo_chain_edge #(.N(2), .RST_VAL(2'b10)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig_i({cs_n_i, sclk_i}),
    .fell_o(fell), .rose_o(rose)
  );

  assign shift_ev = fell[0] && !cs_n_i;
  assign cs_rise  = rose[1];

  sdo_chain_frame_ctl #(.W(WORD_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cs_low_i(!cs_n_i), .cs_rise_i(cs_rise),
    .shift_i(shift_ev), .load_i(load_i), .word_i(word_i),
    .apply_o(load_ev), .apply_word_o(load_word), .busy_o(busy),
    .pend_v_o(pend_v), .pend_msb_o(pend_msb), .cnt_o(cnt)
  );

  sdo_chain_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load_ev), .word_i(load_word),
    .shift_i(shift_ev), .sdi_i(sdi_i), .msb_o(sdo_o)
  );

  assign sdo_oe_o = !cs_n_i;
endmodule

// File: rtl/sdo_chain_port_chk.sv
module sdo_chain_port_chk #(
  parameter int W = 24,
  localparam int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n_i,
  input logic          load_i,
  input logic [W-1:0]  word_i,
  input logic          sdo_o,
  input logic          sdo_oe_o,
  input logic          shift_ev,
  input logic          load_ev,
  input logic          busy,
  input logic          pend_v,
  input logic          pend_msb,
  input logic [CW-1:0] cnt
);
  assert_oe_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |-> !sdo_oe_o);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_ev && !load_ev) |=> $stable(sdo_o));

  assert_direct_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !busy) |=> (sdo_o == $past(word_i[W-1])));

  assert_defer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && busy) |=> pend_v);

  assert_late_apply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && cs_n_i && !$past(cs_n_i) && !load_i)
      |=> (!pend_v && sdo_o == $past(pend_msb)));

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(W));
endmodule

bind sdo_chain_port sdo_chain_port_chk #(.W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .load_i(load_i),
  .word_i(word_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
  .shift_ev(shift_ev), .load_ev(load_ev), .busy(busy),
  .pend_v(pend_v), .pend_msb(pend_msb), .cnt(cnt)
);

// File: tb/sdo_chain_port_test.sv
module sdo_chain_port_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [23:0] word_i = '0;
  logic        sclk_i = 1'b0;
  logic        cs_n_i = 1'b1;
  logic        sdi_i = 1'b0;
  logic        sdo_o;
  logic        sdo_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  sdo_chain_port uut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .word_i(word_i),
    .sclk_i(sclk_i), .cs_n_i(cs_n_i), .sdi_i(sdi_i),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic fall(input logic d);
    sclk_i = 1'b1; step();
    sclk_i = 1'b0; sdi_i = d; step();
  endtask

  task automatic load(input logic [23:0] w);
    word_i = w; load_i = 1'b1; step();
    load_i = 1'b0;
  endtask

  // Checks the current bit, then n falling edges; after edge j the
  // expected bit is exp[n-1-j]. Chain input for edge j is feed[n-j].
  task automatic stream(input string req, input int n,
                        input logic [63:0] exp, input logic [63:0] feed);
    expect_bit(req, sdo_o, exp[n-1]);
    for (int j = 1; j <= n; j++) begin
      fall(feed[n-j]);
      if (j < n) expect_bit(req, sdo_o, exp[n-1-j]);
    end
  endtask

  task automatic t_reset();
    expect_bit("R2 oe off", sdo_oe_o, 1'b0);
    cs_n_i = 1'b0; #1;
    expect_bit("R2 oe on", sdo_oe_o, 1'b1);
    step();
    expect_bit("R1 cleared", sdo_o, 1'b0);
    cs_n_i = 1'b1; step();
  endtask

  task automatic t_basic();
    logic [23:0] w = 24'hB3_5A_C1; // negative value
    load(w);
    step(); step();
    cs_n_i = 1'b0; #1;
    expect_bit("R2 oe at select", sdo_oe_o, 1'b1);
    expect_bit("R3 msb before clock", sdo_o, w[23]);
    stream("R4 R5 word", 24, {40'd0, w}, 64'd0);
    cs_n_i = 1'b1; step();
  endtask

  task automatic t_ignore();
    logic [23:0] w = 24'h69_0F_E2;
    load(w);
    for (int i = 0; i < 5; i++) fall(1'b1);
    expect_bit("R7 no move", sdo_o, w[23]);
    cs_n_i = 1'b0; step();
    stream("R7 word intact", 24, {40'd0, w}, 64'd0);
    cs_n_i = 1'b1; step();
  endtask

  task automatic t_chain();
    logic [23:0] a = 24'hC7_18_3D;
    logic [23:0] b = 24'h2E_94_A6;
    load(a);
    cs_n_i = 1'b0; step();
    stream("R6 chain", 48, {16'd0, a, b}, {16'd0, b, 24'd0});
    cs_n_i = 1'b1; step();
  endtask

  task automatic t_tied();
    logic [23:0] w1 = 24'h81_00_7F;
    logic [23:0] w2 = 24'h7E_FF_80;
    cs_n_i = 1'b0; step();
    load(w1);
    expect_bit("R8 immediate", sdo_o, w1[23]);
    stream("R8 first word", 24, {40'd0, w1}, 64'd0);
    load(w2);
    expect_bit("R8 after full word", sdo_o, w2[23]);
    stream("R8 second word", 24, {40'd0, w2}, 64'd0);
    cs_n_i = 1'b1; step();
  endtask

  task automatic t_defer();
    logic [23:0] w1 = 24'hD2_4B_19;
    logic [23:0] w2 = 24'h35_E6_C8;
    load(w1);
    cs_n_i = 1'b0; step();
    expect_bit("R9 start", sdo_o, w1[23]);
    for (int j = 1; j <= 5; j++) begin
      fall(1'b0);
      expect_bit("R9 head", sdo_o, w1[23-j]);
    end
    load(w2);
    expect_bit("R9 not applied", sdo_o, w1[18]);
    for (int j = 6; j <= 23; j++) begin
      fall(1'b0);
      expect_bit("R9 tail", sdo_o, w1[23-j]);
    end
    sclk_i = 1'b0;
    cs_n_i = 1'b1; step();
    expect_bit("R9 applied at rise", sdo_o, w2[23]);
    cs_n_i = 1'b0; step();
    stream("R9 deferred word", 24, {40'd0, w2}, 64'd0);
    cs_n_i = 1'b1; step();
  endtask

  task automatic t_latest();
    logic [23:0] w1 = 24'hFF_00_FF;
    logic [23:0] w2 = 24'h0F_0F_0F;
    logic [23:0] w3 = 24'h5C_A3_71;
    load(w1);
    cs_n_i = 1'b0; step();
    for (int j = 0; j < 3; j++) fall(1'b0);
    load(w2);
    load(w3);
    cs_n_i = 1'b1; step();
    cs_n_i = 1'b0; step();
    stream("R10 last wins", 24, {40'd0, w3}, 64'd0);
    cs_n_i = 1'b1; step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic();
    t_ignore();
    t_chain();
    t_tied();
    t_defer();
    t_latest();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule